// File: doc/BRIEF.md
# Runtime-Loadable Modulo Step Counter

This block is a W-bit counter that moves forward by a programmable step on every cycle where it is enabled. A limit value governs how it wraps. The counter can be built signed or unsigned. When the limit is positive, the next value is the remainder of the sum divided by the limit, so the count cycles inside [0, limit). When the limit is negative, which is possible only in a signed build, the sum first wraps over the full two's-complement range. If that wrapped sum is negative and at or above the limit, the counter subtracts the limit from it and so jumps back into the non-negative range.

The step and the limit start from parameter defaults after reset, and the count starts from a parameter start value. A single-cycle load strobe takes new start, step and limit values from the input ports. The counter then restarts at the new start value and advances with the new step and limit. Software or a controlling FSM uses this to change the counting pattern without a reset.

Top module: `modstep_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, value becomes START_INIT, and STEP_INIT and LIMIT_INIT become the active step and limit.
- R2: On a cycle with rst_n high, sload low and en low, value keeps its previous contents.
- R3: On a cycle with rst_n high and sload high, value becomes the start port on the next edge, whatever en is.
- R4: The active step and limit change only on a cycle with sload high. At all other times the step, limit and start ports have no effect on the count.
- R5: With a positive active limit, an enabled cycle gives value = (value + step) mod limit. The sum is formed one bit wider than W, so a sum that exceeds 2^W - 1 is reduced correctly.
- R6: In a signed build with a negative limit, an enabled cycle first forms the W-bit two's-complement wrapped sum. If that wrapped sum is negative and greater than or equal to the limit, the next value is the wrapped sum minus the limit.
- R7: In a signed build with a negative limit, when the wrapped sum is non-negative or below the limit, the next value is the wrapped sum itself.
- R8: With an active limit of zero, an enabled cycle gives the plain W-bit wrapped sum.
- R9: In an unsigned build the limit is always taken as a positive number. A limit with its top bit set is a large modulus, not a negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance the count this cycle |
| sload | input | 1 | Load start, step and limit from the ports this cycle |
| start | input | W | Value the count restarts at on a load |
| step | input | W | Increment to install on a load |
| limit | input | W | Wrap limit to install on a load |
| value | output | W | Current count |

## Verification
The hardest case to reach is the negative-limit path. The wrapped sum must land exactly on the limit or between it and zero, and it must also overflow the two's-complement range on the way there. Random steps seldom produce the sequence that crosses the overflow and then hits the correction branch. For that reason a directed load installs start 13, step 3 and limit -10 in a 5-bit signed counter, and the count then passes through both the overflow and the exact-limit hit. The unsigned counter gets a directed load with a sum above 2^W - 1, which tests the one-bit-wider sum. Random loads then mix all three limit classes with random enables.

// File: rtl/modstep_pkg.sv
// Shared types for the modulo step counter.
// Assumes nothing beyond IEEE 1800-2017.
package modstep_pkg;

    // Which wrap rule applies for the currently active limit
    typedef enum logic [1:0] {
        WRAP_FREE = 2'd0,   // zero limit: plain two's-complement wrap
        WRAP_MOD  = 2'd1,   // positive limit: remainder of the wide sum
        WRAP_NEG  = 2'd2    // negative limit: wrap, then subtract limit
    } wrap_mode_e;

    // Classify the limit from its zero and sign flags
    function automatic wrap_mode_e pick_mode(input logic is_zero, input logic is_neg);
        if (is_zero)
            return WRAP_FREE;
        else if (is_neg)
            return WRAP_NEG;
        else
            return WRAP_MOD;
    endfunction

endpackage

// File: rtl/modstep_cfg_reg.sv
// Holds the active step and limit of the counter.
// The register takes the parameter defaults on reset and the port values on a load strobe.
// Assumes the caller gives legal values: a positive step and a limit that is consistent with it.
module modstep_cfg_reg #(
    parameter int          W          = 8,
    parameter logic [W-1:0] STEP_INIT  = 1,
    parameter logic [W-1:0] LIMIT_INIT = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sload,
    input  logic [W-1:0] step_in,
    input  logic [W-1:0] limit_in,
    output logic [W-1:0] step_q,
    output logic [W-1:0] limit_q
);

    // Register the configuration: defaults on reset, ports on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= STEP_INIT;
            limit_q <= LIMIT_INIT;
        end else if (sload) begin
            step_q  <= step_in;
            limit_q <= limit_in;
        end
    end

    // R4: without a load the configuration does not move
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sload |=> ($stable(step_q) && $stable(limit_q)))
        else $error("p_cfg_hold_r4: configuration changed without sload");

endmodule

// File: rtl/modstep_next_calc.sv
// Combinational next-count calculator.
// It forms the sum one bit wider than W, then applies the wrap rule chosen by the limit:
// a remainder for a positive limit, a plain wrap for a zero limit, and, in a signed
// build only, a wrap followed by subtracting the limit for a negative limit.
// Assumes a positive step. In the positive-limit mode it also assumes the current value is non-negative.
module modstep_next_calc
    import modstep_pkg::*;
#(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] nxt,
    output wrap_mode_e   mode
);

    localparam int WS = W + 1;

    logic [WS-1:0] sum_wide;
    logic [W-1:0]  wrapped;
    logic [WS-1:0] divisor;
    logic [W-1:0]  mod_res;
    logic          limit_zero;
    logic          lim_neg;
    logic [W-1:0]  neg_res;

    // Wide sum keeps the carry that a W-bit adder would drop
    assign sum_wide   = {1'b0, cur} + {1'b0, step};
    assign wrapped    = sum_wide[W-1:0];
    assign limit_zero = (limit == '0);
    // Guard the divisor so a zero limit never divides by zero
    assign divisor    = limit_zero ? WS'(1) : {1'b0, limit};
    assign mod_res    = W'(sum_wide % divisor);

    // The signedness parameter decides whether the negative-limit path exists
    generate
        if (SIGNED) begin : g_signed
            logic reached;
            // The wrapped sum is negative and has reached or passed the limit
            assign reached = wrapped[W-1] && ($signed(wrapped) >= $signed(limit));
            assign lim_neg = limit[W-1];
            assign neg_res = reached ? (wrapped - limit) : wrapped;
        end else begin : g_unsigned
            assign lim_neg = 1'b0;
            assign neg_res = wrapped;
        end
    endgenerate

    // Select the wrap rule and the matching result
    always_comb begin
        mode = pick_mode(limit_zero, lim_neg);
        case (mode)
            WRAP_MOD: nxt = mod_res;
            WRAP_NEG: nxt = neg_res;
            default:  nxt = wrapped;
        endcase
    end

endmodule

// File: rtl/modstep_counter.sv
// Runtime-loadable modulo step counter, top level.
// The count register restarts at the start port on a load strobe. The strobe wins over the enable.
// On an enabled cycle the register advances by the active step under the active wrap rule.
// Assumes the caller gives a positive step and a legal start for the chosen limit.
module modstep_counter
    import modstep_pkg::*;
#(
    parameter int           W          = 8,
    parameter bit           SIGNED     = 1'b1,
    parameter logic [W-1:0] START_INIT = 0,
    parameter logic [W-1:0] STEP_INIT  = 1,
    parameter logic [W-1:0] LIMIT_INIT = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sload,
    input  logic [W-1:0] start,
    input  logic [W-1:0] step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] value
);

    logic [W-1:0] step_q;
    logic [W-1:0] limit_q;
    logic [W-1:0] nxt;
    wrap_mode_e   mode;

    modstep_cfg_reg #(
        .W          (W),
        .STEP_INIT  (STEP_INIT),
        .LIMIT_INIT (LIMIT_INIT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sload    (sload),
        .step_in  (step),
        .limit_in (limit),
        .step_q   (step_q),
        .limit_q  (limit_q)
    );

    modstep_next_calc #(
        .W      (W),
        .SIGNED (SIGNED)
    ) u_calc (
        .cur   (value),
        .step  (step_q),
        .limit (limit_q),
        .nxt   (nxt),
        .mode  (mode)
    );

    // Count register: reset, then load, then advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= START_INIT;
        else if (sload)
            value <= start;
        else if (en)
            value <= nxt;
    end

    // R1: reset restores the start default
    p_reset_start_r1: assert property (@(posedge clk)
        !rst_n |=> (value == START_INIT))
        else $error("p_reset_start_r1: value not at start default after reset");

    // R2: an idle cycle holds the count
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sload && !en) |=> $stable(value))
        else $error("p_idle_hold_r2: value moved on an idle cycle");

    // R3: a load places the start port into the count, even when en is high
    p_load_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sload |=> (value == $past(start)))
        else $error("p_load_start_r3: value differs from loaded start");

    // R5: in remainder mode the new count stays below the limit
    p_mod_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sload && mode == WRAP_MOD) |=> (value < $past(limit_q)))
        else $error("p_mod_range_r5: count not below positive limit");

    // R6: after a negative-limit step the count never lies in [limit, -1]
    p_neg_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sload && mode == WRAP_NEG) |=>
            !(value[W-1] && ($signed(value) >= $signed($past(limit_q)))))
        else $error("p_neg_exit_r6: count left inside the corrected band");

    // R8: with a zero limit the count advances by exactly the step
    p_free_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sload && mode == WRAP_FREE) |=> (value == W'($past(value) + $past(step_q))))
        else $error("p_free_wrap_r8: zero-limit step mismatch");

endmodule

// File: tb/tb_modstep_counter.sv
`timescale 1ns/1ps
module tb_modstep_counter;

    logic clk = 1'b0;
    logic rst_n;
    always #2.5 clk = ~clk;

    // Signed 5-bit counter stimulus
    logic s_en, s_ld;
    int   s_start, s_step, s_lim;
    logic [4:0] s_start_v, s_step_v, s_lim_v, val_s;
    assign s_start_v = s_start[4:0];
    assign s_step_v  = s_step[4:0];
    assign s_lim_v   = s_lim[4:0];

    // Unsigned 8-bit counter stimulus
    logic u_en, u_ld;
    int   u_start, u_step, u_lim;
    logic [7:0] u_start_v, u_step_v, u_lim_v, val_u;
    assign u_start_v = u_start[7:0];
    assign u_step_v  = u_step[7:0];
    assign u_lim_v   = u_lim[7:0];

    modstep_counter #(
        .W(5), .SIGNED(1'b1), .START_INIT(5'd7), .STEP_INIT(5'd3), .LIMIT_INIT(5'd13)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(s_en), .sload(s_ld),
        .start(s_start_v), .step(s_step_v), .limit(s_lim_v), .value(val_s)
    );

    modstep_counter #(
        .W(8), .SIGNED(1'b0), .START_INIT(8'd5), .STEP_INIT(8'd7), .LIMIT_INIT(8'd20)
    ) dut_u (
        .clk(clk), .rst_n(rst_n), .en(u_en), .sload(u_ld),
        .start(u_start_v), .step(u_step_v), .limit(u_lim_v), .value(val_u)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    int es, cs_step, cs_lim;
    int eu, cu_step, cu_lim;

    function automatic int wrap5(int x);
        int y;
        y = x & 31;
        if (y >= 16) y = y - 32;
        return y;
    endfunction

    // Signed next count from the requirements R5, R6, R7, R8
    function automatic int ref_s(int v, int s, int l, output string tag);
        int w;
        if (l == 0) begin
            tag = "R8";
            return wrap5(v + s);
        end else if (l > 0) begin
            tag = "R5";
            return (v + s) % l;
        end
        w = wrap5(v + s);
        if (w < 0 && w >= l) begin
            tag = "R6";
            return w - l;
        end
        tag = "R7";
        return w;
    endfunction

    // Unsigned next count from the requirements R5, R8, R9
    function automatic int ref_u(int v, int s, int l, output string tag);
        if (l == 0) begin
            tag = "R8";
            return (v + s) & 255;
        end
        tag = (l >= 128) ? "R9" : "R5";
        return (v + s) % l;
    endfunction

    task automatic chk(string tag, string who, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, who, act, exp);
        end
    endtask

    // One clock: update the model from the current inputs, then compare after the edge
    task automatic tick();
        string ts, tu;
        if (!rst_n) begin
            es = 7; cs_step = 3; cs_lim = 13; ts = "R1";
            eu = 5; cu_step = 7; cu_lim = 20; tu = "R1";
        end else begin
            if (s_ld) begin
                es = s_start; cs_step = s_step; cs_lim = s_lim; ts = "R3";
            end else if (s_en) es = ref_s(es, cs_step, cs_lim, ts);
            else ts = "R2";
            if (u_ld) begin
                eu = u_start; cu_step = u_step; cu_lim = u_lim; tu = "R3";
            end else if (u_en) eu = ref_u(eu, cu_step, cu_lim, tu);
            else tu = "R2";
        end
        @(posedge clk);
        #1;
        chk(ts, "signed", int'($signed(val_s)), es);
        chk(tu, "unsigned", int'(val_u), eu);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        rst_n = 1'b0;
        s_en = 0; s_ld = 0; s_start = 0; s_step = 0; s_lim = 0;
        u_en = 0; u_ld = 0; u_start = 0; u_step = 0; u_lim = 0;
        // R1: reset state
        repeat (3) tick();
        rst_n = 1'b1;

        // R5 with R1 defaults: 10, 0, 3, 6, 9, 12, 2, 5, 8
        s_en = 1; u_en = 1;
        repeat (9) tick();

        // R2 and R4: idle cycles with garbage on the config ports
        s_en = 0; u_en = 0;
        s_start = -5; s_step = 5; s_lim = -3;
        u_start = 1; u_step = 200; u_lim = 3;
        repeat (3) tick();
        // R4: counting still uses the default step and limit
        s_en = 1; u_en = 1;
        repeat (3) tick();

        // R3 with en high; then R6 and R7 sequence, and R9 with a carry out of 8 bits
        s_ld = 1; s_start = 13; s_step = 3; s_lim = -10;
        u_ld = 1; u_start = 199; u_step = 100; u_lim = 200;
        tick();
        s_ld = 0; u_ld = 0;
        repeat (11) tick();

        // R8: zero limit wraps freely
        s_ld = 1; s_start = 14; s_step = 3; s_lim = 0;
        u_ld = 1; u_start = 250; u_step = 9; u_lim = 0;
        tick();
        s_ld = 0; u_ld = 0;
        repeat (4) tick();

        // R1: reset wins over a load and restores the defaults
        rst_n = 1'b0; s_ld = 1; u_ld = 1;
        tick();
        rst_n = 1'b1; s_ld = 0; u_ld = 0;
        repeat (4) tick();

        // Random mix of loads, enables and all limit classes
        for (int i = 0; i < 2000; i++) begin
            s_en = 1'($urandom_range(0, 1));
            u_en = 1'($urandom_range(0, 1));
            s_ld = ($urandom_range(0, 15) == 0);
            u_ld = ($urandom_range(0, 15) == 0);
            if (s_ld) begin
                case ($urandom_range(0, 2))
                    0: begin
                        s_lim = int'($urandom_range(1, 15));
                        s_step = int'($urandom_range(1, 15));
                        s_start = int'($urandom_range(0, 32'(s_lim - 1)));
                    end
                    1: begin
                        s_lim = -int'($urandom_range(1, 16));
                        s_step = int'($urandom_range(1, 15));
                        s_start = int'($urandom_range(0, 31)) - 16;
                    end
                    default: begin
                        s_lim = 0;
                        s_step = int'($urandom_range(1, 15));
                        s_start = int'($urandom_range(0, 31)) - 16;
                    end
                endcase
            end
            if (u_ld) begin
                u_lim = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 255));
                u_step = int'($urandom_range(1, 255));
                u_start = (u_lim == 0) ? int'($urandom_range(0, 255))
                                       : int'($urandom_range(0, 32'(u_lim - 1)));
            end
            tick();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule